// File: doc/BRIEF.md
# Tunnel Bandwidth Allocation Sequencer

This block is the manager side of bandwidth reservation for a tunnelled USB3 path. It runs every step as single-word reads and writes on a simple request/response register bus aimed at one adapter's capability window. A command names the adapter (its base address, whether it is a downstream USB3 adapter, and its route) and one of three operations. *Query* reports the amounts already allocated. *Allocate* grants at least what the caller asks for. *Release* gives back everything above what is in use, but never goes below a fixed floor.

Every operation is wrapped in a handshake:
- The block raises a manager-request flag in the allocation register.
- It waits until the host mirrors that flag in the consumed register.
- It does its work.
- It drops the flag and waits for the host to drop its copy.

The acknowledge poll is spaced in time and limited by a timeout. Both are derived from a clock-frequency parameter. At the end, the block pulses `done` with a status code and the granted upstream and downstream amounts, in allocation units at the adapter's scale.

The state machine has the following states and transitions:
- **S_IDLE** accepts a command. It goes to S_SET_RD, or to S_FINISH for an invalid command.
- **S_SET_RD → S_SET_WR** raises the request flag by read-modify-write.
- **S_POLL** reads the consumed register.
  - On a match in the set phase it goes to S_SCALE_RD.
  - On a match in the clear phase it goes to S_FINISH.
  - On a mismatch it goes to S_WAIT, then back to S_POLL.
  - On a timeout or bus error it goes to S_FINISH.
- **S_SCALE_RD → S_BODY_RD** reads the scale register, then the allocation register.
  - A query then goes to S_CLR_RD.
  - Allocate and release go on to S_BODY_WR, then to S_CLR_RD.
- **S_CLR_RD → S_CLR_WR → S_POLL** drops the request flag and waits for the host to follow.
- **S_FINISH → S_IDLE** ends the operation.
- A bus error in S_SCALE_RD, S_BODY_RD or S_BODY_WR goes straight to S_CLR_RD.

Top module: `tunnel_bw_seq`

## Requirements
- R1: While idle, `busy` is 0. A command taken with `cmd_valid` raises `busy` from the next cycle. When the operation ends, `done` is high for exactly one cycle with `busy` low and `status` valid. Status codes are: 0 ok, 1 invalid, 2 bus error, 3 timeout.
- R2: A command is invalid, and ends with status 1 without any bus request, if any of these holds:
  - `cmd_usb3_down` is 0;
  - `cmd_route` is nonzero;
  - `cmd_op` is 3.
  The valid operation codes are 0 query, 1 allocate and 2 release.
- R3: `bus_req` stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ack` is sampled high.
- R4: Each operation first reads the allocation register (base+2). It then writes the value back with bit 31 (the request flag) set and all other bits unchanged.
- R5: After each flag write, the consumed register (base+1) is read until its bit 31 equals the flag value just written. Consecutive reads are at least POLL_US microseconds of clock cycles apart.
- R6: If the set-phase acknowledge has not arrived once TIMEOUT_MS of cycles have passed since the flag write, the operation ends with status 3.
- R7: Allocate writes, per direction, the larger of the requested amount and the consumed amount. Upstream is bits 11:0 and downstream is bits 23:12, in both the consumed and the allocation register. The value written is reported on `res_up` and `res_dn`.
- R8: Release writes, per direction, the larger of the consumed amount and a floor. The floor is ceil(FLOOR_MBPS·125 / 2^(9+s)), where s is bits 5:0 of the scale register (base+3). The written values and s are reported.
- R9: Query reports the allocated fields of the allocation register, and it leaves those fields unchanged.
- R10: After the body, whether it succeeded or ended in a bus error, the flag is cleared by read-modify-write and its acknowledge is awaited. A failure in the set phase ends the operation without a clear.
- R11: A bus error ends with status 2. When several failures occur in one operation, the first one is the status reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Start a command (taken only while idle) |
| cmd_op | input | 2 | 0 query, 1 allocate, 2 release |
| cmd_usb3_down | input | 1 | Target is a downstream USB3 adapter |
| cmd_route | input | ROUTE_W | Route of the target's router, must be zero |
| cmd_base | input | ADDR_W | Base address of the adapter capability window |
| cmd_up | input | BW_W | Requested upstream amount (allocate) |
| cmd_dn | input | BW_W | Requested downstream amount (allocate) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 2 | Result code, valid with done |
| res_up | output | BW_W | Granted or allocated upstream amount |
| res_dn | output | BW_W | Granted or allocated downstream amount |
| res_scale | output | SCALE_W | Scale read from the adapter |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Access complete (one cycle) |
| bus_err | input | 1 | Access failed, valid with bus_ack |
| bus_rdata | input | DATA_W | Read data, valid with bus_ack |

## Verification
The bench targets the following corner cases:
- **Release below the floor, at several scales.** A design that ignored the scale, or truncated instead of rounding up, would write a floor one unit low.
- **Allocate with the request below consumption.** A design without the max would under-reserve.
- **Host acknowledge delayed over several polls.** This exposes a design that proceeds on a stale flag or polls without spacing.
- **Host that never acknowledges.** A design without the timeout would hang. One that cleared after a set-phase failure would issue a second write.
- **Bus errors at set time and mid-body, including a mid-body error followed by a clear-phase timeout.** This catches a design that skipped the clear, or that overwrote the first error with the later one.

// File: rtl/tunnel_bw_seq_pkg.sv
package tunnel_bw_seq_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_INVALID = 2'd1,
        ST_BUSERR  = 2'd2,
        ST_TIMEOUT = 2'd3
    } status_e;

    localparam logic [1:0] OP_QUERY   = 2'd0;
    localparam logic [1:0] OP_ALLOC   = 2'd1;
    localparam logic [1:0] OP_RELEASE = 2'd2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SET_RD,
        S_SET_WR,
        S_POLL,
        S_WAIT,
        S_SCALE_RD,
        S_BODY_RD,
        S_BODY_WR,
        S_CLR_RD,
        S_CLR_WR,
        S_FINISH
    } state_e;

endpackage

// File: rtl/tunnel_bw_timer.sv
module tunnel_bw_timer #(
    parameter longint GAP_CYC = 5000,
    parameter longint TMO_CYC = 150000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_clr,
    input  logic tmo_clr,
    output logic gap_done,
    output logic tmo_expired
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [GW-1:0] GAP_END = GW'(GAP_CYC);
    localparam logic [TW-1:0] TMO_END = TW'(TMO_CYC);

    logic [GW-1:0] gap_q;
    logic [TW-1:0] tmo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            tmo_q <= '0;
        end else begin
            if (gap_clr)
                gap_q <= '0;
            else if (gap_q != GAP_END)
                gap_q <= gap_q + 1'b1;
            if (tmo_clr)
                tmo_q <= '0;
            else if (tmo_q != TMO_END)
                tmo_q <= tmo_q + 1'b1;
        end
    end

    assign gap_done    = (gap_q == GAP_END);
    assign tmo_expired = (tmo_q == TMO_END);

endmodule

// File: rtl/tunnel_bw_grant.sv
module tunnel_bw_grant #(
    parameter int BW_W       = 12,
    parameter int SCALE_W    = 6,
    parameter int UNIT_LOG2  = 9,
    parameter int FLOOR_MBPS = 1000
) (
    input  logic                   is_release,
    input  logic [SCALE_W-1:0]     scale,
    input  logic [1:0][BW_W-1:0]   want,
    input  logic [1:0][BW_W-1:0]   used,
    output logic [1:0][BW_W-1:0]   grant
);
    localparam int          NDIR     = 2;
    localparam logic [63:0] FLOOR_UF = 64'(FLOOR_MBPS) * 64'd125;
    localparam logic [63:0] MAX_BW   = (64'd1 << BW_W) - 64'd1;

    int unsigned    sh;
    logic [63:0]    quo;
    logic [BW_W-1:0] floor_bw;

    always_comb begin
        sh = 32'(UNIT_LOG2) + 32'(scale);
        if (FLOOR_UF == 64'd0)
            quo = 64'd0;
        else if (sh >= 32'd63)
            quo = 64'd1;
        else
            quo = (FLOOR_UF + (64'd1 << sh) - 64'd1) >> sh;
        floor_bw = (quo > MAX_BW) ? '1 : quo[BW_W-1:0];
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        logic [BW_W-1:0] cand;
        assign cand     = is_release ? floor_bw : want[g];
        assign grant[g] = (cand > used[g]) ? cand : used[g];
    end

endmodule

// File: rtl/tunnel_bw_seq.sv
module tunnel_bw_seq
    import tunnel_bw_seq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int ROUTE_W    = 8,
    parameter int BW_W       = 12,
    parameter int SCALE_W    = 6,
    parameter int UNIT_LOG2  = 9,
    parameter int FLOOR_MBPS = 1000,
    parameter int CLK_HZ     = 100000000,
    parameter int POLL_US    = 50,
    parameter int TIMEOUT_MS = 1500,
    parameter int OFS_CONS   = 1,
    parameter int OFS_ALLOC  = 2,
    parameter int OFS_SCALE  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic               cmd_usb3_down,
    input  logic [ROUTE_W-1:0] cmd_route,
    input  logic [ADDR_W-1:0]  cmd_base,
    input  logic [BW_W-1:0]    cmd_up,
    input  logic [BW_W-1:0]    cmd_dn,
    output logic               busy,
    output logic               done,
    output logic [1:0]         status,
    output logic [BW_W-1:0]    res_up,
    output logic [BW_W-1:0]    res_dn,
    output logic [SCALE_W-1:0] res_scale,
    output logic               bus_req,
    output logic               bus_we,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ack,
    input  logic               bus_err,
    input  logic [DATA_W-1:0]  bus_rdata
);
    localparam int     REQ_BIT = DATA_W - 1;
    localparam int     FLD_W   = 2 * BW_W;
    localparam longint GAP_RAW = (longint'(CLK_HZ) * longint'(POLL_US)) / 64'sd1000000;
    localparam longint TMO_RAW = (longint'(CLK_HZ) * longint'(TIMEOUT_MS)) / 64'sd1000;
    localparam longint GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;
    localparam longint TMO_CYC = (TMO_RAW < 1) ? 1 : TMO_RAW;

    state_e                 state_q, state_d;
    status_e                err_q, err_evt, status_q;
    logic [1:0]             op_q;
    logic [ADDR_W-1:0]      base_q;
    logic [1:0][BW_W-1:0]   req_q, cons_q, grant, res_q;
    logic [SCALE_W-1:0]     scale_q;
    logic [DATA_W-1:0]      word_q;
    logic                   clearing_q, done_q;
    logic                   cmd_ok, acc_ok, acc_bad;
    logic                   gap_clr, tmo_clr, gap_done, tmo_expired;
    logic                   in_body_wr, in_clr_wr;

    assign cmd_ok  = cmd_usb3_down && (cmd_route == '0) && (cmd_op != 2'd3);
    assign acc_ok  = bus_ack && !bus_err;
    assign acc_bad = bus_ack && bus_err;

    tunnel_bw_timer #(.GAP_CYC(GAP_CYC), .TMO_CYC(TMO_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .gap_clr(gap_clr), .tmo_clr(tmo_clr),
        .gap_done(gap_done), .tmo_expired(tmo_expired)
    );

    tunnel_bw_grant #(.BW_W(BW_W), .SCALE_W(SCALE_W), .UNIT_LOG2(UNIT_LOG2),
                      .FLOOR_MBPS(FLOOR_MBPS)) u_grant (
        .is_release(op_q == OP_RELEASE), .scale(scale_q),
        .want(req_q), .used(cons_q), .grant(grant)
    );

    // next state and error events
    always_comb begin
        state_d = state_q;
        err_evt = ST_OK;
        gap_clr = 1'b0;
        tmo_clr = 1'b0;
        unique case (state_q)
            S_IDLE:
                if (cmd_valid) state_d = cmd_ok ? S_SET_RD : S_FINISH;
            S_SET_RD:
                if (bus_ack) state_d = bus_err ? S_FINISH : S_SET_WR;
            S_SET_WR, S_CLR_WR:
                if (bus_ack) begin
                    if (bus_err) state_d = S_FINISH;
                    else begin
                        state_d = S_POLL;
                        tmo_clr = 1'b1;
                    end
                end
            S_POLL:
                if (bus_ack) begin
                    if (bus_err)
                        state_d = S_FINISH;
                    else if (bus_rdata[REQ_BIT] == !clearing_q)
                        state_d = clearing_q ? S_FINISH : S_SCALE_RD;
                    else if (tmo_expired) begin
                        state_d = S_FINISH;
                        err_evt = ST_TIMEOUT;
                    end else begin
                        state_d = S_WAIT;
                        gap_clr = 1'b1;
                    end
                end
            S_WAIT:
                if (gap_done) state_d = S_POLL;
            S_SCALE_RD:
                if (bus_ack) state_d = bus_err ? S_CLR_RD : S_BODY_RD;
            S_BODY_RD:
                if (bus_ack) state_d = (bus_err || op_q == OP_QUERY) ? S_CLR_RD : S_BODY_WR;
            S_BODY_WR:
                if (bus_ack) state_d = S_CLR_RD;
            S_CLR_RD:
                if (bus_ack) state_d = bus_err ? S_FINISH : S_CLR_WR;
            S_FINISH:
                state_d = S_IDLE;
            default:
                state_d = S_IDLE;
        endcase
        if (acc_bad && state_q != S_IDLE && state_q != S_WAIT && state_q != S_FINISH)
            err_evt = ST_BUSERR;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath captures
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q      <= ST_OK;
            status_q   <= ST_OK;
            op_q       <= OP_QUERY;
            base_q     <= '0;
            req_q      <= '0;
            cons_q     <= '0;
            res_q      <= '0;
            scale_q    <= '0;
            word_q     <= '0;
            clearing_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= (state_q == S_FINISH);
            if (state_q == S_FINISH) status_q <= err_q;
            if (state_q == S_IDLE && cmd_valid) begin
                err_q      <= cmd_ok ? ST_OK : ST_INVALID;
                op_q       <= cmd_op;
                base_q     <= cmd_base;
                req_q      <= {cmd_dn, cmd_up};
                clearing_q <= 1'b0;
            end else if (err_evt != ST_OK && err_q == ST_OK) begin
                err_q <= err_evt;
            end
            if (state_d == S_CLR_RD) clearing_q <= 1'b1;
            if (acc_ok) begin
                unique case (state_q)
                    S_SET_RD, S_CLR_RD:
                        word_q <= bus_rdata;
                    S_POLL:
                        if (!clearing_q && bus_rdata[REQ_BIT])
                            cons_q <= {bus_rdata[FLD_W-1:BW_W], bus_rdata[BW_W-1:0]};
                    S_SCALE_RD:
                        scale_q <= bus_rdata[SCALE_W-1:0];
                    S_BODY_RD: begin
                        word_q <= bus_rdata;
                        if (op_q == OP_QUERY)
                            res_q <= {bus_rdata[FLD_W-1:BW_W], bus_rdata[BW_W-1:0]};
                    end
                    S_BODY_WR:
                        res_q <= grant;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = base_q + ADDR_W'(OFS_ALLOC);
        bus_wdata = '0;
        unique case (state_q)
            S_SET_RD, S_BODY_RD, S_CLR_RD:
                bus_req = 1'b1;
            S_SET_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = word_q | (DATA_W'(1) << REQ_BIT);
            end
            S_BODY_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = {1'b1, word_q[DATA_W-2:FLD_W], grant[1], grant[0]};
            end
            S_CLR_WR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_wdata = word_q & ~(DATA_W'(1) << REQ_BIT);
            end
            S_POLL: begin
                bus_req  = 1'b1;
                bus_addr = base_q + ADDR_W'(OFS_CONS);
            end
            S_SCALE_RD: begin
                bus_req  = 1'b1;
                bus_addr = base_q + ADDR_W'(OFS_SCALE);
            end
            default: ;
        endcase
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;
    assign status     = status_q;
    assign res_up     = res_q[0];
    assign res_dn     = res_q[1];
    assign res_scale  = scale_q;
    assign in_body_wr = (state_q == S_BODY_WR);
    assign in_clr_wr  = (state_q == S_CLR_WR);

endmodule

// File: rtl/tunnel_bw_seq_chk.sv
module tunnel_bw_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BW_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              busy,
    input logic              done,
    input logic              in_body_wr,
    input logic              in_clr_wr,
    input logic [BW_W-1:0]   cons_up,
    input logic [BW_W-1:0]   cons_dn
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    p_bus_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy);

    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_no_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_body_wr |-> (bus_wdata[BW_W-1:0] >= cons_up) && (bus_wdata[2*BW_W-1:BW_W] >= cons_dn));

    p_body_keeps_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_body_wr |-> bus_we && bus_wdata[DATA_W-1]);

    p_clear_drops_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_clr_wr |-> bus_we && !bus_wdata[DATA_W-1]);

endmodule

bind tunnel_bw_seq tunnel_bw_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BW_W(BW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .done(done),
    .in_body_wr(in_body_wr), .in_clr_wr(in_clr_wr),
    .cons_up(cons_q[0]), .cons_dn(cons_q[1])
);

// File: tb/tunnel_bw_seq_test.sv
module tunnel_bw_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_usb3_down = 1'b0;
    logic [7:0]  cmd_route = 8'd0;
    logic [15:0] cmd_base = 16'd0;
    logic [11:0] cmd_up = 12'd0, cmd_dn = 12'd0;
    logic        busy, done;
    logic [1:0]  status;
    logic [11:0] res_up, res_dn;
    logic [5:0]  res_scale;
    logic        bus_req, bus_we;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = 32'd0;

    localparam int GAP = 5;
    localparam int TMO = 1000;

    tunnel_bw_seq #(.CLK_HZ(1000000), .POLL_US(5), .TIMEOUT_MS(1)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_usb3_down(cmd_usb3_down), .cmd_route(cmd_route), .cmd_base(cmd_base),
        .cmd_up(cmd_up), .cmd_dn(cmd_dn), .busy(busy), .done(done), .status(status),
        .res_up(res_up), .res_dn(res_dn), .res_scale(res_scale),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0, cyc = 0;
    // host model state
    logic [31:0] alloc_reg;
    logic [11:0] cons_up, cons_dn;
    logic [5:0]  scale_reg;
    logic        hca = 1'b0, target = 1'b0;
    int ack_delay = 0, remaining = 0, err_at = 0, max_lat = 0, lat_left = 0;
    bit never_ack = 0, stick = 0, holding = 0;
    int txn = 0, nwrites = 0, npolls = 0, hold_viol = 0;
    logic [15:0] p_addr;
    logic        p_we;
    logic [31:0] p_wdata;
    // results of last op
    logic [1:0]  r_status;
    logic [11:0] r_up, r_dn;
    logic [5:0]  r_scale;
    int r_dur;
    bit r_busy;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_floor(input int s);
        longint d = 64'sd1 << (9 + s);
        return int'((64'sd125000 + d - 1) / d);
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic respond();
        txn++;
        bus_ack = 1'b1;
        if (txn == err_at) begin
            bus_err = 1'b1;
            return;
        end
        if (bus_we) begin
            if (bus_addr == cmd_base + 16'd2) begin
                alloc_reg = bus_wdata;
                nwrites++;
                target = bus_wdata[31];
                remaining = ack_delay;
            end
        end else if (bus_addr == cmd_base + 16'd1) begin
            npolls++;
            if (hca != target && !never_ack && !(stick && !target)) begin
                if (remaining == 0) hca = target;
                else remaining--;
            end
            bus_rdata = {hca, 7'h55, cons_dn, cons_up};
        end else if (bus_addr == cmd_base + 16'd2) begin
            bus_rdata = alloc_reg;
        end else if (bus_addr == cmd_base + 16'd3) begin
            bus_rdata = {26'h2AAAAAA, scale_reg};
        end else begin
            bus_rdata = 32'hDEADBEEF;
        end
    endtask

    // register-bus responder, drives at the falling edge
    initial forever begin
        @(negedge clk);
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (rst_n && bus_req) begin
            if (holding && (bus_addr != p_addr || bus_we != p_we || bus_wdata != p_wdata))
                hold_viol++;
            if (lat_left > 0) begin
                lat_left--;
                holding = 1;
                p_addr = bus_addr;
                p_we = bus_we;
                p_wdata = bus_wdata;
            end else begin
                respond();
                holding = 0;
                lat_left = $urandom_range(max_lat, 0);
            end
        end else begin
            holding = 0;
        end
    end

    task automatic knobs(input int dly, input bit never, input bit stk, input int erra, input int lat);
        ack_delay = dly;
        never_ack = never;
        stick = stk;
        err_at = erra;
        max_lat = lat;
    endtask

    task automatic run_op(input logic [1:0] op, input logic down, input logic [7:0] route,
                          input logic [11:0] up, input logic [11:0] dn);
        bit got = 0;
        int t0;
        @(negedge clk);
        txn = 0;
        nwrites = 0;
        npolls = 0;
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_usb3_down = down;
        cmd_route = route;
        cmd_up = up;
        cmd_dn = dn;
        t0 = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        r_busy = busy;
        for (int i = 0; i < 5000 && !got; i++) begin
            if (done) begin
                got = 1;
                r_status = status;
                r_up = res_up;
                r_dn = res_dn;
                r_scale = res_scale;
                r_dur = cyc - t0;
            end else begin
                @(negedge clk);
            end
        end
        if (!got) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            r_status = 2'bxx;
        end
    endtask

    task automatic setup_host(input logic [11:0] cu, input logic [11:0] cd, input logic [5:0] sc,
                              input logic [31:0] al);
        cons_up = cu;
        cons_dn = cd;
        scale_reg = sc;
        alloc_reg = al;
        cmd_base = 16'($urandom_range(16'hFFF0, 0));
    endtask

    initial begin
        logic [31:0] a0;
        void'($urandom(32'd17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R1 reset done", done, 0);
        chk("R2 reset bus_req", bus_req, 0);

        // invalid commands
        knobs(0, 0, 0, 0, 1);
        setup_host(12'd10, 12'd10, 6'd0, 32'h0);
        run_op(2'd1, 1'b0, 8'd0, 12'd5, 12'd5);
        chk("R2 not downstream status", r_status, 1);
        chk("R2 not downstream bus txns", txn, 0);
        run_op(2'd2, 1'b1, 8'd5, 12'd5, 12'd5);
        chk("R2 nonzero route status", r_status, 1);
        chk("R2 nonzero route bus txns", txn, 0);
        run_op(2'd3, 1'b1, 8'd0, 12'd5, 12'd5);
        chk("R2 bad op status", r_status, 1);

        // allocate below / above consumption
        a0 = 32'h3A000000;
        setup_host(12'd400, 12'd50, 6'd0, a0);
        run_op(2'd1, 1'b1, 8'd0, 12'd100, 12'd900);
        chk("R1 busy after accept", r_busy, 1);
        chk("R7 status", r_status, 0);
        chk("R7 up keeps consumed", r_up, 400);
        chk("R7 dn takes request", r_dn, 900);
        chk("R7 alloc reg up", alloc_reg[11:0], 400);
        chk("R7 alloc reg dn", alloc_reg[23:12], 900);
        chk("R4 other bits kept", alloc_reg[30:24], 7'h3A);
        chk("R10 flag cleared", alloc_reg[31], 0);
        chk("R10 three writes", nwrites, 3);

        // release floor at several scales
        setup_host(12'd0, 12'd300, 6'd0, 32'h00ABC123);
        run_op(2'd2, 1'b1, 8'd0, 12'd0, 12'd0);
        chk("R8 floor scale0 up", r_up, 245);
        chk("R8 above floor dn", r_dn, 300);
        chk("R8 scale reported", r_scale, 0);
        setup_host(12'd0, 12'd0, 6'd8, 32'h00ABC123);
        run_op(2'd2, 1'b1, 8'd0, 12'd0, 12'd0);
        chk("R8 floor scale8 up", r_up, 1);
        chk("R8 scale8 reported", r_scale, 8);
        setup_host(12'd3, 12'd1, 6'd3, 32'h0);
        run_op(2'd2, 1'b1, 8'd0, 12'd0, 12'd0);
        chk("R8 floor scale3 dn", r_dn, 31);

        // query
        setup_host(12'd7, 12'd7, 6'd2, 32'h15123456);
        run_op(2'd0, 1'b1, 8'd0, 12'd1, 12'd1);
        chk("R9 query up", r_up, 12'h456);
        chk("R9 query dn", r_dn, 12'h123);
        chk("R9 fields unchanged", alloc_reg[23:0], 24'h123456);
        chk("R9 two writes only", nwrites, 2);

        // delayed acknowledge
        knobs(6, 0, 0, 0, 0);
        setup_host(12'd20, 12'd20, 6'd0, 32'h0);
        run_op(2'd1, 1'b1, 8'd0, 12'd30, 12'd10);
        chk("R5 status", r_status, 0);
        chk("R5 poll reads", npolls, 14);
        chk("R5 poll spacing", (r_dur >= 12 * GAP) ? 1 : 0, 1);

        // host never acknowledges
        knobs(0, 1, 0, 0, 0);
        setup_host(12'd20, 12'd20, 6'd0, 32'h0);
        run_op(2'd1, 1'b1, 8'd0, 12'd30, 12'd10);
        chk("R6 timeout status", r_status, 3);
        chk("R6 waited timeout", (r_dur >= TMO) ? 1 : 0, 1);
        chk("R10 no clear after set failure", nwrites, 1);

        // bus error at set write
        knobs(0, 0, 0, 2, 0);
        setup_host(12'd20, 12'd20, 6'd0, 32'h0);
        run_op(2'd1, 1'b1, 8'd0, 12'd30, 12'd10);
        chk("R11 set error status", r_status, 2);
        chk("R10 set error no further txn", txn, 2);

        // bus error at scale read, clear still runs
        knobs(0, 0, 0, 4, 0);
        setup_host(12'd20, 12'd20, 6'd0, 32'h0);
        run_op(2'd2, 1'b1, 8'd0, 12'd0, 12'd0);
        chk("R11 body error status", r_status, 2);
        chk("R10 cleared after body error", alloc_reg[31], 0);
        chk("R10 clear write issued", nwrites, 2);

        // body error then clear-phase timeout: first error wins
        knobs(0, 0, 1, 4, 0);
        setup_host(12'd20, 12'd20, 6'd0, 32'h0);
        run_op(2'd2, 1'b1, 8'd0, 12'd0, 12'd0);
        chk("R11 first error kept", r_status, 2);
        hca = 1'b0;
        target = 1'b0;

        // constrained random
        knobs(0, 0, 0, 0, 2);
        for (int k = 0; k < 36; k++) begin
            logic [1:0]  op = 2'($urandom_range(2, 0));
            logic [11:0] cu = ($urandom_range(1, 0) == 1) ? 12'($urandom_range(300, 0)) : 12'($urandom);
            logic [11:0] cd = ($urandom_range(1, 0) == 1) ? 12'($urandom_range(300, 0)) : 12'($urandom);
            logic [11:0] qu = 12'($urandom), qd = 12'($urandom);
            logic [5:0]  sc = 6'($urandom_range(10, 0));
            logic [31:0] al = {1'b0, 31'($urandom)};
            int eu, ed;
            ack_delay = $urandom_range(3, 0);
            setup_host(cu, cd, sc, al);
            run_op(op, 1'b1, 8'd0, qu, qd);
            if (op == 2'd1) begin
                eu = max2(qu, cu);
                ed = max2(qd, cd);
            end else if (op == 2'd2) begin
                eu = max2(cu, exp_floor(sc));
                ed = max2(cd, exp_floor(sc));
            end else begin
                eu = al[11:0];
                ed = al[23:12];
            end
            chk("R7 R8 R9 random status", r_status, 0);
            chk("R7 R8 R9 random up", r_up, eu);
            chk("R7 R8 R9 random dn", r_dn, ed);
            chk("R4 random field reg", alloc_reg[23:0], {ed[11:0], eu[11:0]});
            chk("R4 random kept bits", alloc_reg[30:24], al[30:24]);
            chk("R10 random flag low", alloc_reg[31], 0);
        end

        chk("R3 request held stable", hold_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule